// File: doc/BRIEF.md
# Leading and Trailing Zero Counter

This combinational unit reports how many zero bits sit at one end of an operand. A direction select, taken from the most significant bit of an extended-opcode field, chooses which end: set means the count starts at bit 0 and moves upward (trailing zeros). Clear means the count starts at the top of the examined field and moves downward (leading zeros). A mode flag narrows the examined field from the full 64-bit operand to its low 32 bits.

Both directions share one lowest-set-bit encoder. For leading zeros the examined field is bit-reversed before it reaches the encoder. A constant one is placed just above the examined field, so an operand with no set bit in the field yields the field width without a separate zero detector. The count is zero-extended into a 64-bit result that can be written straight back to a register file.

Top module: `zero_count_unit`

## Requirements
- R1: Direction is taken from `ext_opcode[9]`: 1 selects a trailing-zero count and 0 selects a leading-zero count.
- R2: With `word_mode` = 1 only `operand[31:0]` is examined, and the result lies in 0..32.
- R3: With `word_mode` = 0 all 64 operand bits are examined, and the result lies in 0..64.
- R4: A trailing-zero count equals the index of the lowest set bit of the examined field.
- R5: A leading-zero count equals (field width − 1) minus the index of the highest set bit of the examined field.
- R6: When the examined field has no set bit, the result is 32 in word mode and 64 in doubleword mode, in either direction.
- R7: The count is zero-extended: `count_out[63:7]` is always zero.
- R8: In word mode, `operand[63:32]` has no effect on the result.
- R9: `ext_opcode[8:0]` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | 64 | Value whose zero bits are counted |
| word_mode | input | 1 | 1: examine the low 32 bits only; 0: examine all 64 bits |
| ext_opcode | input | 10 | Extended opcode field; only its top bit, the direction select, is used |
| count_out | output | 64 | Zero count, zero-extended |

## Verification
The assertions are evaluated whenever the inputs change. They check the result ranges in each mode and the cleared upper result bits. They also check that the encoder lands on a set bit with no set bit below it, and that an empty examined field yields exactly the field width. None of these shows that the correct field was reversed and chosen, or that bits outside the field and the low opcode bits are ignored. Only the bench shows those points, by comparing each result against an arithmetic model: every single-bit position, the zero operand, and random operands, in both modes and both directions, with garbage in the ignored inputs.

// File: rtl/zc_pkg.sv
package zc_pkg;
   // Encodes the direction select taken from the opcode field
   typedef enum logic {
      ZC_LEADING  = 1'b0,
      ZC_TRAILING = 1'b1
   } zc_dir_e;

   // Encodes the examined field width
   typedef enum logic {
      ZC_DWORD = 1'b0,
      ZC_WORD  = 1'b1
   } zc_mode_e;
endpackage

// File: rtl/zc_bit_reverse.sv
module zc_bit_reverse #(
   parameter int unsigned WIDTH = 64
) (
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (WIDTH < 2) begin : g_bad_width
      $error("zc_bit_reverse: WIDTH must be at least 2");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_swap
      assign dout[i] = din[WIDTH-1-i];
   end
endmodule

// File: rtl/zc_lowest_set.sv
module zc_lowest_set #(
   parameter int unsigned WIDTH = 65,
   localparam int unsigned IDX_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] vec,
   output logic [IDX_W-1:0] idx
);
   if (WIDTH < 2) begin : g_bad_width
      $error("zc_lowest_set: WIDTH must be at least 2");
   end

   // Scan downward so the lowest set bit is the last one written
   always_comb begin
      idx = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end

   logic [WIDTH-1:0] below_mask;
   always_comb begin
      below_mask = (WIDTH'(1) << idx) - WIDTH'(1);
      if (!$isunknown(vec) && vec != '0) begin
         AST_HITS_SET_BIT: assert (vec[idx]) else $error("index not on a set bit"); // R4
         AST_NOTHING_BELOW: assert ((vec & below_mask) == '0) else $error("set bit below index"); // R4
      end
   end
endmodule

// File: rtl/zero_count_unit.sv
module zero_count_unit
   import zc_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned HALF_W = 32,
   parameter int unsigned XO_W   = 10,
   localparam int unsigned SCAN_W = DATA_W + 1,
   localparam int unsigned CNT_W  = $clog2(SCAN_W)
) (
   input  logic [DATA_W-1:0] operand,
   input  logic              word_mode,
   input  logic [XO_W-1:0]   ext_opcode,
   output logic [DATA_W-1:0] count_out
);
   if (DATA_W != 2 * HALF_W) begin : g_bad_split
      $error("zero_count_unit: DATA_W must be twice HALF_W");
   end
   if (XO_W < 2) begin : g_bad_xo
      $error("zero_count_unit: XO_W must be at least 2");
   end
   if (CNT_W >= DATA_W) begin : g_bad_cnt
      $error("zero_count_unit: count does not fit the result");
   end

   zc_dir_e  dir;
   zc_mode_e mode;
   assign dir  = zc_dir_e'(ext_opcode[XO_W-1]);
   assign mode = zc_mode_e'(word_mode);

   logic unused_xo_low;
   assign unused_xo_low = ^ext_opcode[XO_W-2:0];

   logic [HALF_W-1:0] low_half;
   logic [HALF_W-1:0] low_rev;
   logic [DATA_W-1:0] full_rev;
   assign low_half = operand[HALF_W-1:0];

   zc_bit_reverse #(.WIDTH(DATA_W)) u_rev_full (.din(operand),  .dout(full_rev));
   zc_bit_reverse #(.WIDTH(HALF_W)) u_rev_low  (.din(low_half), .dout(low_rev));

   // A sentinel one just above the examined field turns "empty" into "width"
   logic [SCAN_W-1:0] scan_vec;
   always_comb begin
      unique case ({mode, dir})
         {ZC_DWORD, ZC_TRAILING}: scan_vec = {1'b1, operand};
         {ZC_DWORD, ZC_LEADING}:  scan_vec = {1'b1, full_rev};
         {ZC_WORD,  ZC_TRAILING}: scan_vec = {{HALF_W{1'b0}}, 1'b1, low_half};
         default:                 scan_vec = {{HALF_W{1'b0}}, 1'b1, low_rev};
      endcase
   end

   logic [CNT_W-1:0] zero_cnt;
   zc_lowest_set #(.WIDTH(SCAN_W)) u_enc (.vec(scan_vec), .idx(zero_cnt));

   assign count_out = {{(DATA_W-CNT_W){1'b0}}, zero_cnt};

   always_comb begin
      if (!$isunknown({operand, word_mode, ext_opcode})) begin
         AST_WORD_RANGE: assert (!word_mode || count_out <= DATA_W'(HALF_W)) else $error("word count out of range"); // R2
         AST_DWORD_RANGE: assert (count_out <= DATA_W'(DATA_W)) else $error("count out of range"); // R3
         AST_UPPER_CLEAR: assert (count_out[DATA_W-1:CNT_W] == '0) else $error("upper result bits set"); // R7
         AST_EMPTY_WORD: assert (!(word_mode && low_half == '0) || count_out == DATA_W'(HALF_W)) else $error("empty word count"); // R6
         AST_EMPTY_DWORD: assert (!(!word_mode && operand == '0) || count_out == DATA_W'(DATA_W)) else $error("empty dword count"); // R6
      end
   end
endmodule

// File: tb/zero_count_unit_test.sv
module zero_count_unit_test;
   logic        clk = 1'b0;
   logic [63:0] operand = '0;
   logic        word_mode = 1'b0;
   logic [9:0]  ext_opcode = '0;
   logic [63:0] count_out;
   int          n_checks = 0;
   int          n_errors = 0;
   bit          finished = 0;

   always #4 clk = ~clk;

   zero_count_unit uut (
      .operand(operand), .word_mode(word_mode),
      .ext_opcode(ext_opcode), .count_out(count_out));

   function automatic int model(logic [63:0] a, bit w, bit t);
      int width = w ? 32 : 64;
      if (t) begin
         for (int i = 0; i < width; i++) if (a[i]) return i;
      end else begin
         for (int i = width - 1; i >= 0; i--) if (a[i]) return width - 1 - i;
      end
      return width;
   endfunction

   task automatic apply(logic [63:0] a, bit w, bit t, logic [8:0] low_xo, string req);
      logic [63:0] exp;
      @(negedge clk);
      operand = a; word_mode = w; ext_opcode = {t, low_xo};
      #2;
      exp = 64'(model(a, w, t));
      n_checks++;
      if (count_out !== exp) begin
         n_errors++;
         $display("FAIL %s: op=%h word=%0d trail=%0d actual=%0d expected=%0d",
                  req, a, w, t, count_out, exp);
      end
   endtask

   initial begin
      logic [63:0] r;
      // Reset state: zero operand, doubleword, leading
      #2;
      n_checks++;
      if (count_out !== 64'd64) begin
         n_errors++;
         $display("FAIL R6: initial actual=%0d expected=64", count_out);
      end
      // R4 R5 R1: each single bit, both modes and directions
      for (int m = 0; m < 2; m++)
         for (int d = 0; d < 2; d++)
            for (int p = 0; p < 64; p++)
               apply(64'd1 << p, m[0], d[0], 9'h0, d[0] ? "R4" : "R5");
      // R6: empty field
      for (int m = 0; m < 2; m++)
         for (int d = 0; d < 2; d++)
            apply(64'd0, m[0], d[0], 9'h0, "R6");
      // R8: word mode, only upper half populated
      apply(64'hFFFF_FFFF_0000_0000, 1'b1, 1'b1, 9'h0, "R8");
      apply(64'hFFFF_FFFF_0000_0000, 1'b1, 1'b0, 9'h0, "R8");
      apply(64'h8000_0000_0000_0000, 1'b1, 1'b0, 9'h0, "R8");
      // R2 R3: all ones
      apply('1, 1'b1, 1'b0, 9'h0, "R2");
      apply('1, 1'b0, 1'b0, 9'h0, "R3");
      // R9: low opcode bits toggled
      apply(64'h0000_0100_0000_0000, 1'b0, 1'b1, 9'h1FF, "R9");
      apply(64'h0000_0100_0000_0000, 1'b0, 1'b0, 9'h155, "R9");
      // Random operands, garbage in ignored inputs; R7 covered by full compare
      for (int k = 0; k < 400; k++) begin
         r = {$urandom(), $urandom()};
         if (k % 3 == 0) r = r >> (k % 64);
         if (k % 5 == 0) r = r << (k % 64);
         apply(r, k[0], k[1], 9'($urandom()), (k[0]) ? "R8" : "R7");
      end
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule